// File: doc/BRIEF.md
# Framebuffer Pixel Format Unpacker

This block sits between a framebuffer word fetcher and a display pipeline. It accepts 32-bit framebuffer words on a valid/ready stream and emits one 24-bit RGB pixel with a transparency flag per transfer on a second valid/ready stream. A three-bit format select chooses how each word is carved into pixels. There are three palette-index depths, looked up through a 256-entry colour palette held inside the block. There are two 16-bit direct-colour layouts, one of them with a per-pixel transparency bit. There are two 18-bit layouts: one pixel per word, or four pixels packed into three words. An optional byte reversal is applied to every incoming word before it is carved.

A programmable line width sets how many pixels of each line are real. The source line in memory is padded up to a multiple of four pixels and to whole words, or to whole three-word groups in the packed mode. The block consumes that padding and discards the pixel slots beyond the line width, so exactly the programmed number of pixels leaves per line. The palette is loaded through a separate write port. A palette write takes priority over the pixel path for that cycle, and both streams stall.

The control is a two-state machine. In ST_FILL it accepts words into a 96-bit group buffer. The transition FILL_TO_DRAIN fires when the last word of a unit is accepted: one word for every mode except the packed one, which needs three. In ST_DRAIN it steps through one pixel slot per cycle, and dropped slots step without waiting for the sink. The transition DRAIN_TO_FILL fires when the last slot of the unit has been handled. Configuration is expected to change only between lines while the block is idle in ST_FILL.

Top module: `pix_unpack`

## Requirements
- R1: After reset out_valid is 0, in_ready is 1 and the line position is zero, so the next word starts a new line.
- R2: Format codes 0, 1 and 2 hold 16, 8 and 4 palette indices of 2, 4 and 8 bits per word. The least significant index is emitted first. Each pixel is the palette entry for its index, with out_transp 0.
- R3: Format code 3 carries two pixels per word, low half-word first. Blue is bits 4:0, green bits 10:5 and red bits 15:11. They are widened to 8 bits by shifting left 3, 2 and 3.
- R4: Format code 4 carries two pixels per word, low half-word first. Blue is bits 4:0, green bits 9:5 and red bits 14:10, each shifted left 3. Bit 15 of the half-word is out_transp.
- R5: Format code 5 carries one pixel per word. Blue is bits 5:0, green bits 11:6 and red bits 17:12, each shifted left 2. Codes 5 and 7 behave the same.
- R6: Format code 6 takes three words per four pixels. In the 96-bit value {word2, word1, word0}, pixel k starts at bit 24k as blue, green and red 6-bit fields, each shifted left 2. The green of pixel 1 and the red of pixel 2 cross word boundaries.
- R7: With cfg_swap at 1, the four bytes of every input word are reversed before the word is carved.
- R8: A line consumes pixel slots up to cfg_width rounded up to a multiple of four and to a whole unit of the current mode. Only the first cfg_width slots are emitted.
- R9: While pal_we is 1, in_ready is 0 and no new pixel enters the output register. A palette write affects all lookups made in later cycles.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_rgb and out_transp hold their values.
- R11: No pixel leaves before a whole unit is accepted: one word, or three in format 6. After the last slot of a unit the block returns to accepting words.
- R12: out_rgb carries red in bits 23:16, green in 15:8 and blue in 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 3 | Pixel format code |
| cfg_swap | input | 1 | Reverse bytes of each input word |
| cfg_width | input | LINE_W | Visible pixels per line |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted this cycle when valid |
| in_data | input | 32 | Framebuffer word |
| pal_we | input | 1 | Palette write strobe |
| pal_addr | input | PAL_AW | Palette entry to write |
| pal_data | input | 24 | Palette colour, red in 23:16 |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Sink takes the pixel |
| out_rgb | output | 24 | Pixel colour |
| out_transp | output | 1 | Pixel transparency flag |

## Verification
A wrong word counter or slot counter in this block shows at the ports at once. Colours come out from the wrong bit field or in the wrong order on the first mismatched pixel. A wrong line-position counter first shows at the end of a line with padding: the line carries one pixel too many or too few, and every pixel of the following line shifts. The test uses widths that are not multiples of the unit, so such a fault surfaces within one line. A stale palette entry, or a lost write caused by a bad stall, shows on the first pixel that uses that entry.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

    typedef enum logic [2:0] {
        FMT_IDX2    = 3'd0,
        FMT_IDX4    = 3'd1,
        FMT_IDX8    = 3'd2,
        FMT_RGB565  = 3'd3,
        FMT_RGB555T = 3'd4,
        FMT_RGB666  = 3'd5,
        FMT_RGB666P = 3'd6,
        FMT_RSVD    = 3'd7
    } pix_fmt_e;

    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_DRAIN = 1'b1
    } unpk_state_e;

    typedef struct packed {
        logic [7:0] red;
        logic [7:0] grn;
        logic [7:0] blu;
        logic       transp;
    } pix_t;

    localparam int GROUP_W = 96;

    // pixel slots carried by one unit (word or packed group)
    function automatic logic [4:0] slots_of(input pix_fmt_e f);
        case (f)
            FMT_IDX2:    return 5'd16;
            FMT_IDX4:    return 5'd8;
            FMT_IDX8:    return 5'd4;
            FMT_RGB565:  return 5'd2;
            FMT_RGB555T: return 5'd2;
            FMT_RGB666P: return 5'd4;
            default:     return 5'd1;
        endcase
    endfunction

    // input words making up one unit
    function automatic logic [1:0] words_of(input pix_fmt_e f);
        return (f == FMT_RGB666P) ? 2'd3 : 2'd1;
    endfunction

endpackage

// File: rtl/pix_palette.sv
module pix_palette #(
    parameter int AW     = 8,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/pix_field_decode.sv
module pix_field_decode
    import pix_unpack_pkg::*;
(
    input  pix_fmt_e             fmt,
    input  logic [GROUP_W-1:0]   grp,
    input  logic [3:0]           slot,
    output logic                 is_idx,
    output logic [7:0]           idx,
    output pix_t                 pix
);
    localparam int PK_PIX = 4;
    localparam int PK_PITCH = 24;
    localparam int PK_BITS = 18;

    logic [PK_BITS-1:0] pk [PK_PIX];

    // packed pixels sit on a 24-bit pitch inside the three-word group
    for (genvar k = 0; k < PK_PIX; k++) begin : g_pk
        assign pk[k] = grp[k*PK_PITCH +: PK_BITS];
    end

    logic [31:0] w0;
    logic [15:0] half;
    logic [17:0] six;

    assign w0   = grp[31:0];
    assign half = slot[0] ? w0[31:16] : w0[15:0];

    always_comb begin
        is_idx = 1'b0;
        idx    = '0;
        pix    = '0;
        six    = (fmt == FMT_RGB666P) ? pk[slot[1:0]] : w0[17:0];
        unique case (fmt)
            FMT_IDX2: begin
                is_idx = 1'b1;
                idx    = {6'd0, w0[{slot, 1'b0} +: 2]};
            end
            FMT_IDX4: begin
                is_idx = 1'b1;
                idx    = {4'd0, w0[{slot[2:0], 2'b00} +: 4]};
            end
            FMT_IDX8: begin
                is_idx = 1'b1;
                idx    = w0[{slot[1:0], 3'b000} +: 8];
            end
            FMT_RGB565: begin
                pix.red = {half[15:11], 3'b000};
                pix.grn = {half[10:5], 2'b00};
                pix.blu = {half[4:0], 3'b000};
            end
            FMT_RGB555T: begin
                pix.red    = {half[14:10], 3'b000};
                pix.grn    = {half[9:5], 3'b000};
                pix.blu    = {half[4:0], 3'b000};
                pix.transp = half[15];
            end
            default: begin
                pix.red = {six[17:12], 2'b00};
                pix.grn = {six[11:6], 2'b00};
                pix.blu = {six[5:0], 2'b00};
            end
        endcase
    end

endmodule

// File: rtl/pix_unpack_fsm.sv
module pix_unpack_fsm
    import pix_unpack_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  pix_fmt_e           fmt,
    input  logic               swap,
    input  logic [LINE_W-1:0]  line_width,
    input  logic               in_valid,
    input  logic [31:0]        in_data,
    input  logic               stall,
    input  logic               sink_free,
    output logic               in_ready,
    output logic [GROUP_W-1:0] grp,
    output logic [3:0]         slot,
    output logic               drop,
    output logic               adv
);
    localparam int BYTES = 4;

    unpk_state_e state_q, state_d;
    logic [1:0]         wcnt_q;
    logic [3:0]         slot_q;
    logic [LINE_W-1:0]  col_q;
    logic [GROUP_W-1:0] grp_q;

    logic [31:0]   rev_word;
    logic [31:0]   cap_word;
    logic          in_fire;
    logic          last_word;
    logic          last_slot;
    logic          line_end;
    logic [LINE_W:0] col_nx;
    logic [4:0]    spu;
    logic [1:0]    wpu;

    for (genvar b = 0; b < BYTES; b++) begin : g_rev
        assign rev_word[8*b +: 8] = in_data[8*(BYTES-1-b) +: 8];
    end

    assign cap_word  = swap ? rev_word : in_data;
    assign spu       = slots_of(fmt);
    assign wpu       = words_of(fmt);
    assign in_ready  = (state_q == ST_FILL) && !stall;
    assign in_fire   = in_valid && in_ready;
    assign last_word = (wcnt_q == (wpu - 2'd1));
    assign last_slot = ({1'b0, slot_q} == (spu - 5'd1));
    assign drop      = (col_q >= line_width);
    assign adv       = (state_q == ST_DRAIN) && !stall && (drop || sink_free);
    assign col_nx    = {1'b0, col_q} + {{LINE_W{1'b0}}, 1'b1};
    assign line_end  = last_slot && (col_nx >= {1'b0, line_width}) && (col_nx[1:0] == 2'b00);
    assign grp       = grp_q;
    assign slot      = slot_q;

    // next state: FILL_TO_DRAIN, DRAIN_TO_FILL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:  if (in_fire && last_word) state_d = ST_DRAIN;
            ST_DRAIN: if (adv && last_slot)     state_d = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            slot_q <= '0;
            col_q  <= '0;
            grp_q  <= '0;
        end else begin
            if (in_fire) begin
                if (wcnt_q == 2'd0)      grp_q[31:0]  <= cap_word;
                else if (wcnt_q == 2'd1) grp_q[63:32] <= cap_word;
                else                     grp_q[95:64] <= cap_word;
                wcnt_q <= last_word ? 2'd0 : wcnt_q + 2'd1;
            end
            if (adv) begin
                slot_q <= last_slot ? 4'd0 : slot_q + 4'd1;
                col_q  <= line_end ? '0 : col_nx[LINE_W-1:0];
            end
        end
    end

    AST_SINGLE_WORD_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && fmt != FMT_RGB666P) |=> state_q == ST_DRAIN); // R11

    AST_PACKED_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && fmt == FMT_RGB666P && wcnt_q != 2'd2) |=> state_q == ST_FILL); // R11

    AST_PACKED_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && fmt == FMT_RGB666P && wcnt_q == 2'd2) |=> state_q == ST_DRAIN); // R6

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DRAIN |-> {1'b0, slot_q} < spu); // R8

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
    import pix_unpack_pkg::*;
#(
    parameter int LINE_W = 12,
    parameter int PAL_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_fmt,
    input  logic              cfg_swap,
    input  logic [LINE_W-1:0] cfg_width,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_data,
    input  logic              pal_we,
    input  logic [PAL_AW-1:0] pal_addr,
    input  logic [23:0]       pal_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [23:0]       out_rgb,
    output logic              out_transp
);
    localparam int COLOR_W = 24;

    pix_fmt_e           fmt;
    logic [GROUP_W-1:0] grp;
    logic [3:0]         slot;
    logic               drop;
    logic               adv;
    logic               sink_free;
    logic               is_idx;
    logic [7:0]         idx;
    pix_t               dec_pix;
    logic [COLOR_W-1:0] pal_rd;
    logic               load;

    logic               ov_q;
    logic [COLOR_W-1:0] orgb_q;
    logic               ot_q;

    assign fmt       = pix_fmt_e'(cfg_fmt);
    assign sink_free = !ov_q || out_ready;
    assign load      = adv && !drop;

    pix_unpack_fsm #(.LINE_W(LINE_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt        (fmt),
        .swap       (cfg_swap),
        .line_width (cfg_width),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .stall      (pal_we),
        .sink_free  (sink_free),
        .in_ready   (in_ready),
        .grp        (grp),
        .slot       (slot),
        .drop       (drop),
        .adv        (adv)
    );

    pix_field_decode dec_i (
        .fmt    (fmt),
        .grp    (grp),
        .slot   (slot),
        .is_idx (is_idx),
        .idx    (idx),
        .pix    (dec_pix)
    );

    pix_palette #(.AW(PAL_AW), .DATA_W(COLOR_W)) pal_i (
        .clk     (clk),
        .wr_en   (pal_we),
        .wr_addr (pal_addr),
        .wr_data (pal_data),
        .rd_addr (idx[PAL_AW-1:0]),
        .rd_data (pal_rd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_q   <= 1'b0;
            orgb_q <= '0;
            ot_q   <= 1'b0;
        end else if (load) begin
            ov_q   <= 1'b1;
            orgb_q <= is_idx ? pal_rd : {dec_pix.red, dec_pix.grn, dec_pix.blu};
            ot_q   <= is_idx ? 1'b0 : dec_pix.transp;
        end else if (out_ready) begin
            ov_q   <= 1'b0;
        end
    end

    assign out_valid  = ov_q;
    assign out_rgb    = orgb_q;
    assign out_transp = ot_q;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb) && $stable(out_transp))); // R10

    AST_PAL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we |=> (out_valid == ($past(out_valid) && !$past(out_ready)))); // R9

    AST_DROP_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && drop) |=> (out_valid == ($past(out_valid) && !$past(out_ready)))); // R8

    AST_PAL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (pal_we && in_valid) |=> $stable(grp)); // R9

endmodule

// File: tb/pix_unpack_tb_top.sv
`timescale 1ns/1ps
module pix_unpack_tb_top;
    localparam int LINE_W = 12;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [2:0]        cfg_fmt;
    logic              cfg_swap;
    logic [LINE_W-1:0] cfg_width;
    logic              in_valid;
    logic              in_ready;
    logic [31:0]       in_data;
    logic              pal_we;
    logic [7:0]        pal_addr;
    logic [23:0]       pal_data;
    logic              out_valid;
    logic              out_ready;
    logic [23:0]       out_rgb;
    logic              out_transp;

    always #2 clk = ~clk;

    pix_unpack #(.LINE_W(LINE_W), .PAL_AW(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_swap(cfg_swap),
        .cfg_width(cfg_width), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .pal_we(pal_we), .pal_addr(pal_addr),
        .pal_data(pal_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_rgb(out_rgb), .out_transp(out_transp)
    );

    typedef struct {
        logic [23:0] rgb;
        logic        t;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [23:0] pal_m [256];
    int          checks = 0;
    int          errors = 0;
    bit          mon_on = 0;
    bit          bp_on  = 0;
    bit          done   = 0;
    bit          prev_stall = 0;
    logic [23:0] prev_rgb;
    logic        prev_t;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bswap(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    function automatic int ppw(input int f);
        case (f)
            0: return 16;
            1: return 8;
            2: return 4;
            3, 4: return 2;
            6: return 4;
            default: return 1;
        endcase
    endfunction

    // independent pixel model: returns {transp, rgb}
    function automatic logic [24:0] model(input int f, input logic [95:0] g, input int s);
        logic [31:0] w;
        logic [15:0] h;
        logic [17:0] p;
        int idx;
        w = g[31:0];
        h = w[16*(s%2) +: 16];
        p = g[24*(s%4) +: 18];
        case (f)
            0: begin idx = int'((w >> (2*s)) & 32'h3); return {1'b0, pal_m[idx]}; end
            1: begin idx = int'((w >> (4*s)) & 32'hf); return {1'b0, pal_m[idx]}; end
            2: begin idx = int'((w >> (8*s)) & 32'hff); return {1'b0, pal_m[idx]}; end
            3: return {1'b0, h[15:11], 3'b0, h[10:5], 2'b0, h[4:0], 3'b0};
            4: return {h[15], h[14:10], 3'b0, h[9:5], 3'b0, h[4:0], 3'b0};
            6: return {1'b0, p[17:12], 2'b0, p[11:6], 2'b0, p[5:0], 2'b0};
            default: return {1'b0, w[17:12], 2'b0, w[11:6], 2'b0, w[5:0], 2'b0};
        endcase
    endfunction

    task automatic push_exp(input logic [24:0] m, input string tag);
        exp_t e;
        e.rgb = m[23:0];
        e.t   = m[24];
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic push_word(input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic pal_write(input logic [7:0] a, input logic [23:0] d, input bit chk);
        @(negedge clk);
        pal_we   = 1'b1;
        pal_addr = a;
        pal_data = d;
        pal_m[a] = d;
        #1;
        if (chk) check(in_ready == 1'b0, "R9 in_ready during palette write", {31'd0, in_ready}, 32'd0);
        @(negedge clk);
        pal_we = 1'b0;
    endtask

    task automatic set_cfg(input int f, input bit sw, input int width);
        @(negedge clk);
        cfg_fmt   = 3'(f);
        cfg_swap  = sw;
        cfg_width = LINE_W'(width);
    endtask

    function automatic logic [31:0] gen_word(input int seed, input int i);
        return (32'(seed) * 32'h9E3779B1) ^ (32'(i) * 32'h85EBCA6B) ^ (32'(i) << 7);
    endfunction

    // build words of one line, queue expected pixels, then drive words
    task automatic send_line(input int f, input bit sw, input int width, input int seed, input string tag);
        int unit, padded, nw, wpu, spu;
        logic [31:0] lw [$];
        logic [95:0] g;
        spu    = ppw(f);
        unit   = (spu > 4) ? spu : 4;
        padded = ((width + unit - 1) / unit) * unit;
        wpu    = (f == 6) ? 3 : 1;
        nw     = (padded / spu) * wpu;
        set_cfg(f, sw, width);
        for (int i = 0; i < nw; i++) lw.push_back(gen_word(seed, i));
        for (int u = 0; u < nw / wpu; u++) begin
            g = '0;
            for (int k = 0; k < wpu; k++) g[32*k +: 32] = lw[u*wpu + k];
            for (int s = 0; s < spu; s++) begin
                if (u*spu + s < width) push_exp(model(f, g, s), tag);
            end
        end
        for (int i = 0; i < nw; i++) push_word(sw ? bswap(lw[i]) : lw[i]);
    endtask

    task automatic wait_idle();
        while (sb_q.size() != 0) @(negedge clk);
        repeat (24) @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R11 idle after line",
              {30'd0, in_ready, out_valid}, 32'h2);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        bit nr;
        exp_t e;
        if (mon_on) begin
            if (prev_stall) begin
                check(out_valid && out_rgb == prev_rgb && out_transp == prev_t, "R10 hold under backpressure",
                      {7'd0, out_transp, out_rgb}, {7'd0, prev_t, prev_rgb});
            end
            nr = bp_on ? ($urandom % 4 != 0) : 1'b1;
            out_ready = nr;
            if (out_valid && nr) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8 unexpected pixel", {7'd0, out_transp, out_rgb}, 32'd0);
                end else begin
                    e = sb_q.pop_front();
                    check(out_rgb == e.rgb && out_transp == e.t, e.tag,
                          {7'd0, out_transp, out_rgb}, {7'd0, e.t, e.rgb});
                end
            end
            prev_stall = out_valid && !nr;
            prev_rgb   = out_rgb;
            prev_t     = out_transp;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] wv;
        rst_n = 1'b0; cfg_fmt = 3'd0; cfg_swap = 1'b0; cfg_width = '0;
        in_valid = 1'b0; in_data = '0; pal_we = 1'b0; pal_addr = '0;
        pal_data = '0; out_ready = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
        check(in_ready == 1'b1, "R1 in_ready after reset", {31'd0, in_ready}, 32'd1);

        for (int i = 0; i < 256; i++)
            pal_write(8'(i), {8'(i), ~8'(i), 8'(i) ^ 8'h5A}, 1'b0);
        mon_on = 1;

        send_line(2, 0, 8, 1, "R2 8-bit index");           wait_idle();
        send_line(1, 0, 8, 2, "R2 4-bit index");           wait_idle();
        send_line(0, 0, 16, 3, "R2 2-bit index");          wait_idle();
        send_line(3, 0, 4, 4, "R3 565 R12");               wait_idle();
        send_line(4, 0, 6, 5, "R4 555 transparent");       wait_idle();
        send_line(5, 0, 4, 6, "R5 18-bit unpacked");       wait_idle();
        send_line(6, 0, 8, 7, "R6 18-bit packed");         wait_idle();
        bp_on = 1;
        send_line(3, 1, 4, 8, "R7 swap 565");              wait_idle();
        send_line(6, 1, 4, 9, "R7 swap packed");           wait_idle();
        send_line(5, 0, 5, 10, "R8 width 5 unpacked");     wait_idle();
        send_line(0, 0, 3, 11, "R8 width 3 2-bit");        wait_idle();
        send_line(6, 0, 5, 12, "R8 width 5 packed");       wait_idle();
        send_line(2, 0, 13, 13, "R8 width 13 8-bit");      wait_idle();
        send_line(4, 1, 3, 14, "R4 R8 width 3");           wait_idle();

        // palette write mid-stream stalls input; untouched entry 0xF0
        set_cfg(2, 0, 16);
        for (int i = 0; i < 16; i++) push_exp({1'b0, pal_m[i]}, "R9 stream around write");
        for (int i = 0; i < 2; i++) push_word({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
        pal_write(8'hF0, 24'h13579B, 1'b1);
        for (int i = 2; i < 4; i++) push_word({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
        wait_idle();
        set_cfg(2, 0, 4);
        for (int i = 0; i < 4; i++) push_exp({1'b0, 24'h13579B}, "R9 new entry visible");
        push_word(32'hF0F0F0F0);
        wait_idle();

        // packed mode holds output until the third word
        bp_on = 0;
        set_cfg(6, 0, 4);
        begin
            logic [95:0] g;
            for (int k = 0; k < 3; k++) g[32*k +: 32] = gen_word(21, k);
            for (int s = 0; s < 4; s++) push_exp(model(6, g, s), "R6 R11 packed group");
            push_word(g[31:0]);
            push_word(g[63:32]);
            repeat (6) @(negedge clk);
            check(out_valid == 1'b0, "R11 no pixel before third word", {31'd0, out_valid}, 32'd0);
            wv = g[95:64];
            push_word(wv);
        end
        wait_idle();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule